// File: doc/BRIEF.md
# Strided Vector Memory Address Sequencer

This block walks a long vector memory operand one element at a time and gives out the byte address of each element. A single start pulse captures everything it needs: a base register value, a signed 16-bit displacement, a signed 16-bit stride counted in elements, an operand size code, the first and last positions to process within a 64-element register, and an optional per-element enable mask. The effective address is the base plus the sign-extended displacement. The element at position `first` lands at that address, and each later position lies one scaled stride further on.

Each busy cycle gives one element with its position index and a write enable. When the mask is in use, the write enable comes from the mask bit for that element. An element that the mask turns off still takes its cycle and its address, so the elements that remain stay where they belong in memory. A stride of zero makes the operand a scalar, and every element then reads the same address. A one-cycle done pulse closes each operation, including an empty one in which the first position lies beyond the last.

Top module: `vec_addr_seq`

## Requirements
- R1: After reset, `busy`, `done` and `elem_valid` are low.
- R2: The effective address is `base` plus `disp` sign-extended to 64 bits. The first element issued carries this address.
- R3: The element issued j-th (counting from zero) has the address effective address + j × (sign-extended `stride` shifted left by `size`), taken modulo 2^64. The size code gives the element width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes.
- R4: A zero stride gives every element of the operation the effective address.
- R5: A start taken at a clock edge gives element `first` in the next cycle. The positions then follow one per cycle in ascending order up to `last`. `elem_valid` is high exactly on those cycles, and `elem_idx` shows the position.
- R6: `done` is high for exactly one cycle, in the cycle after the last element. `busy` is low in that cycle.
- R7: `elem_we` equals `mask[elem_idx]` when `mask_en` was high at start, and is 1 otherwise. A masked-off element still takes its cycle and its address.
- R8: When `first` is greater than `last`, no element is issued, and `done` pulses in the cycle after start.
- R9: While `busy` is high, `start` and every operand input are ignored. The operation in flight continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| base | input | 64 | Base register value |
| disp | input | 16 | Signed displacement |
| stride | input | 16 | Signed stride in elements |
| size | input | 2 | Operand size code |
| first_idx | input | 6 | First element position |
| last_idx | input | 6 | Last element position |
| mask_en | input | 1 | Use the mask for write enables |
| mask | input | 64 | Per-position enable bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| elem_valid | output | 1 | Element address is valid this cycle |
| elem_addr | output | 64 | Byte address of the current element |
| elem_idx | output | 6 | Position of the current element |
| elem_we | output | 1 | Write enable of the current element |

## Verification
The hardest situation to reach from the ports is an operation that changes its inputs partway through. Here `start` is asserted again while the block is busy, and the operand inputs change at the same time, which tests whether all state is held from the first start. Runs of that kind are provided directly: `start` is held high and the inputs are scrambled on every cycle of a run except the last. Each address is compared with a value computed fresh from the captured operands. Negative strides that wrap below zero are also covered, along with a masked first element, the one-element ranges at both ends, and an inverted range.

// File: rtl/vec_addr_seq.sv
module vec_addr_seq #(
  parameter int AW    = 64,
  parameter int VLEN  = 64,
  parameter int DISPW = 16,
  parameter int STRW  = 16,
  localparam int IDXW = $clog2(VLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base,
  input  logic [DISPW-1:0] disp,
  input  logic [STRW-1:0]  stride,
  input  logic [1:0]       size,
  input  logic [IDXW-1:0]  first_idx,
  input  logic [IDXW-1:0]  last_idx,
  input  logic             mask_en,
  input  logic [VLEN-1:0]  mask,
  output logic             busy,
  output logic             done,
  output logic             elem_valid,
  output logic [AW-1:0]    elem_addr,
  output logic [IDXW-1:0]  elem_idx,
  output logic             elem_we
);

  logic            busy_q, done_q, men_q;
  logic [AW-1:0]   addr_q, step_q;
  logic [IDXW-1:0] idx_q, last_q;
  logic [VLEN-1:0] mask_q;

  wire            accept = start && !busy_q;
  wire [AW-1:0]   ea     = base + {{(AW-DISPW){disp[DISPW-1]}}, disp};
  wire [AW-1:0]   step_n = {{(AW-STRW){stride[STRW-1]}}, stride} << size;
  wire            at_end = (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      men_q  <= 1'b0;
      addr_q <= '0;
      step_q <= '0;
      idx_q  <= '0;
      last_q <= '0;
      mask_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q <= ea;
        step_q <= step_n;
        idx_q  <= first_idx;
        last_q <= last_idx;
        mask_q <= mask;
        men_q  <= mask_en;
        if (first_idx > last_idx) done_q <= 1'b1;
        else                      busy_q <= 1'b1;
      end else if (busy_q) begin
        if (at_end) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q  <= idx_q + IDXW'(1);
          addr_q <= addr_q + step_q;
        end
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign elem_valid = busy_q;
  assign elem_addr  = addr_q;
  assign elem_idx   = idx_q;
  assign elem_we    = men_q ? mask_q[idx_q] : 1'b1;

  a_r1_reset_idle: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !done);
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> !elem_valid);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r5_idx_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid && $past(elem_valid) |-> elem_idx == $past(elem_idx) + IDXW'(1));
  a_r5_idx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> elem_idx <= last_q);
  a_r8_empty_range: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (first_idx > last_idx) |=> done && !elem_valid);
  a_r9_hold_operands: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(last_q) && $stable(step_q) && $stable(mask_q));
  a_r4_scalar_addr: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid && $past(elem_valid) && step_q == '0 |-> $stable(elem_addr));

endmodule

// File: tb/tb_vec_addr_seq.sv
`timescale 1ns/1ps
module tb_vec_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] base = '0;
  logic [15:0] disp = '0;
  logic [15:0] stride = '0;
  logic [1:0]  size = '0;
  logic [5:0]  first_idx = '0;
  logic [5:0]  last_idx = '0;
  logic        mask_en = 1'b0;
  logic [63:0] mask = '0;
  logic        busy, done, elem_valid, elem_we;
  logic [63:0] elem_addr;
  logic [5:0]  elem_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vec_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .disp(disp),
    .stride(stride), .size(size), .first_idx(first_idx), .last_idx(last_idx),
    .mask_en(mask_en), .mask(mask), .busy(busy), .done(done),
    .elem_valid(elem_valid), .elem_addr(elem_addr), .elem_idx(elem_idx),
    .elem_we(elem_we)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_addr(input logic [63:0] b, input logic [15:0] d,
                                           input logic [15:0] s, input logic [1:0] sz,
                                           input int j);
    logic [63:0] ea, st;
    ea = b + {{48{d[15]}}, d};
    st = {{48{s[15]}}, s} << sz;
    return ea + 64'(j) * st;
  endfunction

  task automatic scramble();
    base = {$urandom, $urandom};
    disp = 16'($urandom);
    stride = 16'($urandom);
    size = 2'($urandom);
    first_idx = 6'($urandom);
    last_idx = 6'($urandom);
    mask_en = 1'($urandom);
    mask = {$urandom, $urandom};
  endtask

  task automatic run(input logic [63:0] b, input logic [15:0] d, input logic [15:0] s,
                     input logic [1:0] sz, input logic [5:0] f, input logic [5:0] l,
                     input logic men, input logic [63:0] m, input bit poke);
    int n;
    @(negedge clk);
    base = b; disp = d; stride = s; size = sz; first_idx = f; last_idx = l;
    mask_en = men; mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (f > l) begin
      check("R8 done after empty start", {63'd0, done}, 64'd1);
      check("R8 no element", {63'd0, elem_valid}, 64'd0);
      @(negedge clk);
      check("R6 done single cycle", {63'd0, done}, 64'd0);
      return;
    end
    n = int'(l) - int'(f) + 1;
    for (int j = 0; j < n; j++) begin
      check("R5 valid", {63'd0, elem_valid}, 64'd1);
      check("R5 index", {58'd0, elem_idx}, 64'(int'(f) + j));
      check(j == 0 ? "R2 first address" : (s == 16'd0 ? "R4 scalar address" : "R3 address"),
            elem_addr, exp_addr(b, d, s, sz, j));
      check("R7 write enable", {63'd0, elem_we}, men ? {63'd0, m[int'(f) + j]} : 64'd1);
      check("R6 no early done", {63'd0, done}, 64'd0);
      if (poke && j < n - 1) begin start = 1'b1; scramble(); end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check("R6 done after last", {63'd0, done}, 64'd1);
    check("R6 busy low at done", {63'd0, busy}, 64'd0);
    check("R5 valid low after last", {63'd0, elem_valid}, 64'd0);
    @(negedge clk);
    check("R6 done single cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    check("R1 busy after reset", {63'd0, busy}, 64'd0);
    check("R1 done after reset", {63'd0, done}, 64'd0);
    check("R1 valid after reset", {63'd0, elem_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {62'd0, busy, elem_valid}, 64'd0);

    run(64'h1000, 16'h0010, 16'd1, 2'd2, 6'd0, 6'd7, 1'b0, '0, 1'b0);
    run(64'h2000, 16'hFFF0, 16'd0, 2'd3, 6'd3, 6'd9, 1'b0, '0, 1'b0);
    run(64'h0000_0000_0000_0010, 16'h0000, 16'hFFFF, 2'd3, 6'd0, 6'd5, 1'b0, '0, 1'b0);
    run(64'hABCD, 16'h0004, 16'd3, 2'd1, 6'd5, 6'd12, 1'b1, 64'hFFFF_FFFF_FFFF_FFDF, 1'b0);
    run(64'h4000, 16'h0, 16'd2, 2'd0, 6'd0, 6'd0, 1'b1, 64'h0, 1'b0);
    run(64'h5000, 16'h8000, 16'd7, 2'd2, 6'd63, 6'd63, 1'b1, 64'h8000_0000_0000_0000, 1'b0);
    run(64'h6000, 16'h0, 16'd1, 2'd0, 6'd0, 6'd63, 1'b1, 64'hA5A5_0F0F_3C3C_FF00, 1'b0);
    run(64'h7000, 16'h0, 16'd1, 2'd0, 6'd20, 6'd10, 1'b0, '0, 1'b0);
    run(64'h9000, 16'h0020, 16'hFFFD, 2'd1, 6'd2, 6'd11, 1'b1, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1);
    run(64'hA000, 16'h0, 16'd5, 2'd3, 6'd40, 6'd50, 1'b0, '0, 1'b1);

    for (int t = 0; t < 40; t++) begin
      logic [15:0] s;
      logic [5:0]  f, l;
      case ($urandom % 4)
        0: s = 16'd0;
        1: s = 16'd1;
        2: s = 16'hFFFF;
        default: s = 16'($urandom);
      endcase
      f = 6'($urandom);
      l = 6'($urandom);
      run({$urandom, $urandom}, 16'($urandom), s, 2'($urandom), f, l,
          1'($urandom), {$urandom, $urandom}, ($urandom % 3) == 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule